// File: doc/BRIEF.md
# Low-Rate Clock Timer with Tap Interrupts

This block keeps time for a software clock. A fast system clock drives it. An internal divider turns that clock into a one-cycle strobe at the nominal 256 Hz rate. Each strobe advances an 8-bit binary counter while the timer is running. Counter bit 0 then toggles at 128 Hz and bit 7 at 1 Hz, and software can read the whole count at any moment.

Four of the counter bits are used as interrupt taps: the 32 Hz, 8 Hz, 2 Hz and 1 Hz bits. When a tap bit falls from 1 to 0 during counting, the matching flag is set. Each flag has its own enable. The block sends one combined request line to an interrupt controller outside the block.

Two inputs come from outside the block. A sleep level suppresses all strobes. A restart pulse, issued when a companion real-time clock starts, puts the divider back to the start of a new period.

Top module: `clock_tick_timer`

## Requirements
- R1: After reset the count is 0, run is off, all enables and flags are 0, and `irq_o` is low.
- R2: While run is on, the count rises by one, modulo 256, on every tick. A tick comes once every `DIV_RATIO` system clocks. With `DIV_RATIO` = 8, 250 ticks from a count of 2 give 252, and 6 further ticks wrap the count to 2.
- R3: While run is off, the count holds its value across ticks.
- R4: Address 0 is the control register. Writing it with bit 1 set clears the count to 0 at that edge. Bit 1 always reads back as 0. Bit 0 of the same write sets run, and counting then continues from 0.
- R5: While `sleep_i` is high, no tick is produced, so the count does not advance.
- R6: A `restart_i` pulse clears the divider and cancels any tick in the same cycle. The next tick comes exactly `DIV_RATIO` clocks after the edge that sampled the pulse.
- R7: Flag bits 0 to 3 at address 2 are set when counter bits 2, 4, 6 and 7, in that order, fall during a counting step. A flag is set whatever the state of its enable.
- R8: Writing 1 to a flag bit at address 2 clears that flag. If the same flag is set by a fall in the same cycle, the set wins.
- R9: `irq_o` is high exactly when some flag is set and its enable is also set. The enables are bits 0 to 3 at address 1 and follow the same order as the flags.
- R10: Address 3 reads the live 8-bit count. Bits of the control, enable and flag registers that have no function read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | High while the chip is in sleep; suppresses ticks |
| restart_i | input | 1 | One-cycle pulse that restarts the divider phase |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for reads and writes |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 8 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The checker assumes that `sleep_i`, `restart_i` and the register strobe are synchronous to `clk`. It also assumes `DIV_RATIO` is at least 2, so that a cycle after a restart can never carry a tick. The bench changes every input on the falling clock edge and reads results half a period after a rising edge. It combines each run/reset write with a restart pulse in the same cycle, so the tick phase is known exactly from that edge onwards. The one check that depends on a same-cycle event, the clear-versus-set race, is timed by counting whole divider periods from that aligned edge.

// File: rtl/ctt_pkg.sv
package ctt_pkg;

  localparam int CNT_W    = 8;
  localparam int NUM_TAPS = 4;
  localparam int WR_W     = NUM_TAPS;
  localparam int RD_W     = CNT_W;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_IRQEN = 2'd1,
    ADDR_FLAG  = 2'd2,
    ADDR_COUNT = 2'd3
  } reg_addr_e;

  // counter bit that drives tap number idx (32, 8, 2, 1 Hz)
  function automatic int tap_bit(input int idx);
    case (idx)
      0:       return 2;
      1:       return 4;
      2:       return 6;
      default: return 7;
    endcase
  endfunction

  // bit b goes 1 -> 0 on an increment exactly when bits b..0 are all ones
  function automatic logic bit_falls(input logic [CNT_W-1:0] c, input int b);
    logic [CNT_W-1:0] m;
    m = {CNT_W{1'b1}} >> (CNT_W - 1 - b);
    return (c & m) == m;
  endfunction

endpackage

// File: rtl/ctt_tick_gen.sv
module ctt_tick_gen #(
  parameter int DIV_RATIO = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic restart_i,
  output logic tick_o
);

  localparam int DIV_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV_RATIO - 1);

  logic [DIV_W-1:0] div_cnt;
  logic             wrap;

  assign wrap = (div_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div_cnt <= '0;
    else if (restart_i)  div_cnt <= '0;
    else if (wrap)       div_cnt <= '0;
    else                 div_cnt <= div_cnt + DIV_W'(1);
  end

  // sleep removes the strobe; restart cancels the pending one
  assign tick_o = wrap & ~sleep_i & ~restart_i;

endmodule

// File: rtl/ctt_counter.sv
module ctt_counter
  import ctt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_i,
  input  logic                step_i,
  output logic [CNT_W-1:0]    count_o,
  output logic [NUM_TAPS-1:0] tap_fall_o
);

  logic [CNT_W-1:0] count_q;
  logic             advance;

  assign advance = step_i & ~clear_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (clear_i)  count_q <= '0;
    else if (advance)  count_q <= count_q + CNT_W'(1);
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tap_fall_o[g] = advance & bit_falls(count_q, tap_bit(g));
  end

  assign count_o = count_q;

endmodule

// File: rtl/ctt_irq_ctrl.sv
module ctt_irq_ctrl
  import ctt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TAPS-1:0] set_i,
  input  logic [NUM_TAPS-1:0] clr_i,
  input  logic                en_we_i,
  input  logic [NUM_TAPS-1:0] en_wdata_i,
  output logic [NUM_TAPS-1:0] flags_o,
  output logic [NUM_TAPS-1:0] en_o,
  output logic                irq_o
);

  logic [NUM_TAPS-1:0] flags_q;
  logic [NUM_TAPS-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= '0;
    else if (en_we_i)  en_q <= en_wdata_i;
  end

  // a set in the same cycle beats a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign irq_o   = |(flags_q & en_q);

endmodule

// File: rtl/clock_tick_timer.sv
module clock_tick_timer
  import ctt_pkg::*;
#(
  parameter int DIV_RATIO = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_i,
  input  logic            restart_i,
  input  logic            reg_we_i,
  input  logic [1:0]      reg_addr_i,
  input  logic [WR_W-1:0] reg_wdata_i,
  output logic [RD_W-1:0] reg_rdata_o,
  output logic            irq_o
);

  reg_addr_e           addr;
  logic                wr_ctrl, wr_en, wr_flag;
  logic                run_q;
  logic                sw_clear;
  logic                tick;
  logic                step;
  logic [CNT_W-1:0]    count;
  logic [NUM_TAPS-1:0] tap_fall;
  logic [NUM_TAPS-1:0] flag_clr;
  logic [NUM_TAPS-1:0] flags;
  logic [NUM_TAPS-1:0] en;

  assign addr     = reg_addr_e'(reg_addr_i);
  assign wr_ctrl  = reg_we_i && (addr == ADDR_CTRL);
  assign wr_en    = reg_we_i && (addr == ADDR_IRQEN);
  assign wr_flag  = reg_we_i && (addr == ADDR_FLAG);
  assign sw_clear = wr_ctrl & reg_wdata_i[CTRL_CLR_BIT];
  assign flag_clr = wr_flag ? reg_wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= 1'b0;
    else if (wr_ctrl)  run_q <= reg_wdata_i[CTRL_RUN_BIT];
  end

  ctt_tick_gen #(.DIV_RATIO(DIV_RATIO)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_i   (sleep_i),
    .restart_i (restart_i),
    .tick_o    (tick)
  );

  assign step = run_q & tick;

  ctt_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (sw_clear),
    .step_i     (step),
    .count_o    (count),
    .tap_fall_o (tap_fall)
  );

  ctt_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (tap_fall),
    .clr_i      (flag_clr),
    .en_we_i    (wr_en),
    .en_wdata_i (reg_wdata_i),
    .flags_o    (flags),
    .en_o       (en),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (addr)
      ADDR_CTRL:  reg_rdata_o[CTRL_RUN_BIT] = run_q;
      ADDR_IRQEN: reg_rdata_o[NUM_TAPS-1:0] = en;
      ADDR_FLAG:  reg_rdata_o[NUM_TAPS-1:0] = flags;
      default:    reg_rdata_o = count;
    endcase
  end

endmodule

// File: rtl/ctt_checks.sv
module ctt_checks
  import ctt_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                sleep_i,
  input logic                restart_i,
  input logic                tick,
  input logic                run_q,
  input logic                sw_clear,
  input logic [CNT_W-1:0]    count,
  input logic [NUM_TAPS-1:0] tap_fall,
  input logic [NUM_TAPS-1:0] flag_clr,
  input logic [NUM_TAPS-1:0] flags,
  input logic                irq_o
);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !sw_clear) |=> (count == $past(count) + CNT_W'(1)));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run_q && tick) && !sw_clear) |=> $stable(count));

  // R4
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |=> (count == '0));

  // R5
  sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> !tick);

  // R6
  restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !tick);

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tap_fall) |=> ((flags & $past(tap_fall)) == $past(tap_fall)));

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_clr & ~tap_fall)) |=> ((flags & $past(flag_clr & ~tap_fall)) == '0));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|flags));

endmodule

bind clock_tick_timer ctt_checks u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep_i   (sleep_i),
  .restart_i (restart_i),
  .tick      (tick),
  .run_q     (run_q),
  .sw_clear  (sw_clear),
  .count     (count),
  .tap_fall  (tap_fall),
  .flag_clr  (flag_clr),
  .flags     (flags),
  .irq_o     (irq_o)
);

// File: tb/test_clock_tick_timer.sv
module test_clock_tick_timer;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;
  localparam int WATCHDOG   = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_i = 1'b0;
  logic       restart_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [3:0] reg_wdata_i = 4'd0;
  logic [7:0] reg_rdata_o;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clock_tick_timer #(.DIV_RATIO(DIV)) i_clock_tick_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_i     (sleep_i),
    .restart_i   (restart_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o)
  );

  // vector: control write {clear, run}, ticks to wait, expected count
  typedef struct packed {
    logic       clr;
    logic       run;
    logic [9:0] ticks;
    logic [7:0] exp_cnt;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{clr:1'b0, run:1'b1, ticks:10'd5,   exp_cnt:8'd5},   // R2
    '{clr:1'b0, run:1'b1, ticks:10'd3,   exp_cnt:8'd8},   // R2
    '{clr:1'b0, run:1'b0, ticks:10'd4,   exp_cnt:8'd8},   // R3
    '{clr:1'b1, run:1'b1, ticks:10'd2,   exp_cnt:8'd2},   // R4
    '{clr:1'b0, run:1'b1, ticks:10'd250, exp_cnt:8'd252}, // R2
    '{clr:1'b0, run:1'b1, ticks:10'd6,   exp_cnt:8'd2},   // R2 wrap
    '{clr:1'b1, run:1'b0, ticks:10'd3,   exp_cnt:8'd0}    // R3 R4
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  // control write together with a restart pulse: aligns the tick phase
  task automatic ctl_restart(input logic clr, input logic run);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = {2'b00, clr, run};
    restart_i = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0; restart_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic [7:0] model;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 8'h00);
    rd(2'd1, d); check("R1 enables", d, 8'h00);
    rd(2'd2, d); check("R1 flags", d, 8'h00);
    rd(2'd3, d); check("R1 count", d, 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);

    // vector table walk with independent model
    model = 8'd0;
    for (int i = 0; i < NVEC; i++) begin
      ctl_restart(VECS[i].clr, VECS[i].run);
      if (VECS[i].clr) model = 8'd0;
      if (VECS[i].run) model = model + 8'(VECS[i].ticks);
      waitc(int'(VECS[i].ticks) * DIV);
      rd(2'd3, d);
      check("R2/R3/R4 vector count", d, VECS[i].exp_cnt);
      check("R10 count model", d, model);
    end

    // R4 clear bit reads back 0, run reads 1
    ctl_restart(1'b1, 1'b1);
    rd(2'd0, d); check("R4 ctrl readback", d, 8'h01);

    // R6 phase after restart
    ctl_restart(1'b1, 1'b1);
    waitc(DIV - 1);
    rd(2'd3, d); check("R6 no tick before period", d, 8'd0);
    waitc(1);
    rd(2'd3, d); check("R6 tick after one period", d, 8'd1);
    waitc(2);
    @(negedge clk); restart_i = 1'b1;
    @(negedge clk); restart_i = 1'b0;
    waitc(DIV - 1);
    rd(2'd3, d); check("R6 re-phased, still 1", d, 8'd1);
    waitc(1);
    rd(2'd3, d); check("R6 re-phased tick", d, 8'd2);

    // R5 sleep
    @(negedge clk); sleep_i = 1'b1;
    ctl_restart(1'b1, 1'b1);
    waitc(5 * DIV);
    rd(2'd3, d); check("R5 sleep holds count", d, 8'd0);
    sleep_i = 1'b0;
    waitc(3 * DIV);
    rd(2'd3, d); check("R5 counting after sleep", d, 8'd3);

    // R7 R9 flags and interrupt
    wr(2'd1, 4'h0);
    wr(2'd2, 4'hF);
    ctl_restart(1'b1, 1'b1);
    waitc(7 * DIV);
    rd(2'd2, d); check("R7 no flag at count 7", d, 8'h00);
    waitc(DIV);
    rd(2'd2, d); check("R7 32Hz tap flag with enable off", d, 8'h01);
    check("R9 irq low with enable off", {7'd0, irq_o}, 8'h00);
    wr(2'd1, 4'h1);
    check("R9 irq high with enable on", {7'd0, irq_o}, 8'h01);
    wr(2'd2, 4'h1);
    rd(2'd2, d); check("R8 flag cleared", d, 8'h00);
    check("R9 irq low after clear", {7'd0, irq_o}, 8'h00);
    ctl_restart(1'b0, 1'b1);
    waitc(248 * DIV);
    rd(2'd3, d); check("R2 wrap to 0", d, 8'h00);
    rd(2'd2, d); check("R7 all four taps", d, 8'h0F);
    wr(2'd1, 4'h8);
    check("R9 irq from 1Hz tap", {7'd0, irq_o}, 8'h01);

    // R8 set beats clear in the same cycle
    wr(2'd1, 4'h0);
    wr(2'd2, 4'hF);
    ctl_restart(1'b1, 1'b1);
    waitc(8 * DIV - 1);
    reg_we_i = 1'b1; reg_addr_i = 2'd2; reg_wdata_i = 4'h1;
    @(negedge clk);
    reg_we_i = 1'b0;
    rd(2'd2, d); check("R8 set wins over clear", d, 8'h01);

    summary();
    $finish;
  end

endmodule